// File: doc/BRIEF.md
# Serial Port Status Flags and Shared Interrupt

This block keeps the status flags of a serial communication port and drives its single interrupt request. The receiver core pulses strobes when a character completes, when the line goes idle and when it sees noise or a framing fault. The transmitter core pulses strobes when its holding buffer empties and when a character has fully left the shift stage. Each strobe sets a sticky flag. Overrun is derived inside the block: a character that completes while the previous one has not been collected raises it, and the holding register is not reloaded.

Software clears the flags through register access sequences, not by writing to them. A status read arms a one-shot sequence. If the next register access is a data read, the receive-ready flag clears. If the next access is a data write, the two transmit flags clear. The idle flag and the three receive error flags are cleared only by taking receive-enable low. Every flag is gated with its own enable, and the results are ORed onto the one request line. Taking the interrupt clears nothing.

Top module: `serial_status_ctrl`

## Requirements
- R1: The status vector has these bits: bit 0 receive-ready, bit 1 transmit-empty, bit 2 transmit-complete, bit 3 idle, bit 4 overrun, bit 5 noise, bit 6 framing. `irq` is high in the same cycle whenever some status bit and the `irq_en` bit of the same index are both 1, and it is low otherwise.
- R2: A `rx_done` pulse sets receive-ready at the next clock edge. The flag clears at the edge that ends a data read (select, read strobe, `bus_addr`=1) when that read is the first register access after a status read (select, read strobe, `bus_addr`=0).
- R3: A transmit-empty or transmit-complete strobe sets its flag. Both flags clear at the edge that ends a data write (select, write strobe, `bus_addr`=1) when that write is the first register access after a status read.
- R4: The idle flag clears at any edge where `rx_en` is low, including a single low cycle. Data accesses do not clear it.
- R5: The overrun, noise and framing flags clear only at edges where `rx_en` is low. Status-then-data sequences leave them unchanged.
- R6: A data access with no armed status read clears nothing. Any register access other than the matching data access cancels the arming: a status write, an access to another address, or a data access of the wrong kind. Cycles without select keep the arming.
- R7: If a set strobe and a clear condition hit the same flag in the same cycle, the flag is 1 after the edge.
- R8: When `rx_done` arrives while receive-ready is set and is not being cleared in that cycle, overrun sets and `rx_load` stays low. When receive-ready is clear, or is being cleared in that cycle, `rx_load` follows `rx_done`.
- R9: Writes to the status address change no flag.
- R10: When synchronous reset is active, every flag and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address (0 status, 1 data) |
| rx_done | input | 1 | Receiver completed a character |
| tx_empty_set | input | 1 | Transmit holding buffer became empty |
| tx_done_set | input | 1 | Transmission of a character finished |
| idle_set | input | 1 | Idle line detected |
| noise_set | input | 1 | Noise detected on a received character |
| frame_set | input | 1 | Framing fault on a received character |
| rx_en | input | 1 | Receive enable |
| irq_en | input | 7 | Per-flag interrupt enables, same indices as `status` |
| status | output | 7 | Flag vector |
| rx_load | output | 1 | Permission to load the receive holding register |
| irq | output | 1 | Shared interrupt request |

## Verification
Two functions can act on the same flag in the same cycle: a core strobe setting it, and a clear from a completed access sequence or from receive-enable low. The bench provokes this on purpose. It pulses `rx_done` during the data read that consumes receive-ready, pulses transmit-empty during the data write that clears it, and pulses idle while receive-enable is low. It then checks that the flag is still set after the edge. The receive case also checks that overrun does not rise and that `rx_load` is granted in that same cycle, because the old character counts as consumed.

// File: rtl/ssc_pkg.sv
// Package: shared flag indices and the flag vector type for the serial
// status controller. Assumes every other file of the block imports it.
package ssc_pkg;
    localparam int NFLAG    = 7;
    localparam int F_RDY    = 0;
    localparam int F_TXE    = 1;
    localparam int F_TXC    = 2;
    localparam int F_IDLE   = 3;
    localparam int F_OVR    = 4;
    localparam int F_NOISE  = 5;
    localparam int F_FRAME  = 6;

    typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/ssc_access_seq.sv
// Module: tracks the status-read-then-data-access clear sequence.
// A status read arms it. The first later register access either completes
// it (a data read or a data write) or cancels it. Cycles without select
// leave the arming alone. Assumes the strobes are qualified by select.
module ssc_access_seq #(
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 0,
    parameter int DATA_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              clr_on_rd,
    output logic              clr_on_wr
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

    logic armed_q;
    logic access;
    logic stat_rd;
    logic data_hit;

    // Purpose: decode the kind of access presented this cycle.
    always_comb begin
        access   = sel && (rd || wr);
        stat_rd  = sel && rd && (addr == STAT_A);
        data_hit = sel && (addr == DATA_A);
    end

    // Purpose: a data access completes the sequence only while armed.
    always_comb begin
        clr_on_rd = armed_q && data_hit && rd;
        clr_on_wr = armed_q && data_hit && wr;
    end

    // Purpose: arm on a status read, disarm on any other access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (access)
            armed_q <= stat_rd;
    end

    // A completed clear cannot be followed at once by another clear.
    AST_ONE_SHOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_on_rd || clr_on_wr) |=> !(clr_on_rd || clr_on_wr)); // R6
endmodule

// File: rtl/ssc_flag_cell.sv
// Module: one sticky status flag. A set strobe wins over a clear in the
// same cycle. Assumes set and clr are single-cycle conditions computed
// by the parent.
module ssc_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Purpose: hold the flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
        else if (clr)
            q <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q); // R6
endmodule

// File: rtl/ssc_irq_merge.sv
// Module: gates each flag with its own enable and ORs the results onto
// one request line. Purely combinational; assumes flag and enable share
// bit indices.
module ssc_irq_merge #(
    parameter int N = 7
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enables,
    output logic         req
);
    logic [N-1:0] gated;

    for (genvar i = 0; i < N; i++) begin : g_gate
        // Purpose: one enabled cause per bit.
        assign gated[i] = flags[i] & enables[i];
    end

    // Purpose: merge all causes onto the shared line.
    always_comb req = |gated;

    always_comb begin
        if (flags == '0) AST_IRQ_QUIET: assert (!req); // R1
    end
endmodule

// File: rtl/serial_status_ctrl.sv
// Module: status flags and shared interrupt of a serial port. Flags are
// set by strobes from the receiver and transmitter cores, cleared by
// status-then-data access sequences or by receive-enable low, and
// combined with per-flag enables into one request. Assumes the strobes
// are single-cycle pulses synchronous to clk.
module serial_status_ctrl
    import ssc_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 0,
    parameter int DATA_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              rx_done,
    input  logic              tx_empty_set,
    input  logic              tx_done_set,
    input  logic              idle_set,
    input  logic              noise_set,
    input  logic              frame_set,
    input  logic              rx_en,
    input  logic [NFLAG-1:0]  irq_en,
    output logic [NFLAG-1:0]  status,
    output logic              rx_load,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    logic      clr_rd;
    logic      clr_wr;
    flag_vec_t set_v;
    flag_vec_t clr_v;
    flag_vec_t flag_q;

    ssc_access_seq #(
        .ADDR_W   (ADDR_W),
        .STAT_ADDR(STAT_ADDR),
        .DATA_ADDR(DATA_ADDR)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (bus_sel),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .clr_on_rd(clr_rd),
        .clr_on_wr(clr_wr)
    );

    // Purpose: map core strobes to flag set conditions; overrun derived here.
    always_comb begin
        set_v          = '0;
        set_v[F_RDY]   = rx_done;
        set_v[F_TXE]   = tx_empty_set;
        set_v[F_TXC]   = tx_done_set;
        set_v[F_IDLE]  = idle_set;
        set_v[F_OVR]   = rx_done && flag_q[F_RDY] && !clr_rd;
        set_v[F_NOISE] = noise_set;
        set_v[F_FRAME] = frame_set;
    end

    // Purpose: map access sequences and receive-enable to clear conditions.
    always_comb begin
        clr_v          = '0;
        clr_v[F_RDY]   = clr_rd;
        clr_v[F_TXE]   = clr_wr;
        clr_v[F_TXC]   = clr_wr;
        clr_v[F_IDLE]  = !rx_en;
        clr_v[F_OVR]   = !rx_en;
        clr_v[F_NOISE] = !rx_en;
        clr_v[F_FRAME] = !rx_en;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        ssc_flag_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (set_v[i]),
            .clr  (clr_v[i]),
            .q    (flag_q[i])
        );
    end

    // Purpose: the holding register may load unless unread data would be lost.
    always_comb rx_load = rx_done && (!flag_q[F_RDY] || clr_rd);

    always_comb status = flag_q;

    ssc_irq_merge #(.N(NFLAG)) u_irq (
        .flags  (flag_q),
        .enables(irq_en),
        .req    (irq)
    );

    AST_RDY_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && !rx_done) |=> !status[F_RDY]); // R2
    AST_TX_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !tx_empty_set && !tx_done_set) |=> (status[F_TXE:F_TXC] == 2'b00)); // R3
    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !idle_set) |=> !status[F_IDLE]); // R4
    AST_ERR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !noise_set && !frame_set && !rx_done) |=> (status[F_FRAME:F_OVR] == 3'b000)); // R5
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_load) |=> status[F_OVR]); // R8
    AST_STAT_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_rd && bus_addr == STAT_A && rx_en && set_v == '0) |=> $stable(status)); // R9
endmodule

// File: tb/sim_serial_status_ctrl.sv
// Bench: a vector table walked by one loop, then directed corner tests.
module sim_serial_status_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       rx_done = 1'b0, tx_empty_set = 1'b0, tx_done_set = 1'b0;
    logic       idle_set = 1'b0, noise_set = 1'b0, frame_set = 1'b0;
    logic       rx_en = 1'b1;
    logic [6:0] irq_en = 7'h7F;
    logic [6:0] status;
    logic       rx_load;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    serial_status_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .rx_done(rx_done),
        .tx_empty_set(tx_empty_set), .tx_done_set(tx_done_set),
        .idle_set(idle_set), .noise_set(noise_set), .frame_set(frame_set),
        .rx_en(rx_en), .irq_en(irq_en), .status(status), .rx_load(rx_load),
        .irq(irq)
    );

    // cmd = {sel, rd, wr}; set = {rx_done, tx_empty, tx_done, idle, noise, frame}
    typedef struct packed {
        logic [2:0] cmd;
        logic [1:0] addr;
        logic [5:0] set;
        logic       en;
        logic [6:0] exp;
        logic [3:0] req;
    } row_t;

    localparam int NROW = 26;
    localparam row_t TBL [NROW] = '{
        '{3'b000, 2'd0, 6'b100000, 1'b1, 7'b0000001, 4'd2},  // R2 set ready
        '{3'b000, 2'd0, 6'b011000, 1'b1, 7'b0000111, 4'd3},  // R3 set tx flags
        '{3'b110, 2'd1, 6'b000000, 1'b1, 7'b0000111, 4'd6},  // R6 unarmed data read
        '{3'b110, 2'd0, 6'b000000, 1'b1, 7'b0000111, 4'd2},  // R2 status read arms
        '{3'b000, 2'd0, 6'b000000, 1'b1, 7'b0000111, 4'd6},  // R6 gap keeps arming
        '{3'b110, 2'd1, 6'b000000, 1'b1, 7'b0000110, 4'd2},  // R2 ready clears
        '{3'b110, 2'd0, 6'b000000, 1'b1, 7'b0000110, 4'd3},  // R3 arm
        '{3'b101, 2'd1, 6'b000000, 1'b1, 7'b0000000, 4'd3},  // R3 tx flags clear
        '{3'b000, 2'd0, 6'b100000, 1'b1, 7'b0000001, 4'd2},  // R2
        '{3'b000, 2'd0, 6'b100000, 1'b1, 7'b0010001, 4'd8},  // R8 overrun
        '{3'b110, 2'd0, 6'b000000, 1'b1, 7'b0010001, 4'd9},  // R9 arm
        '{3'b101, 2'd0, 6'b000000, 1'b1, 7'b0010001, 4'd9},  // R9 status write inert
        '{3'b110, 2'd1, 6'b000000, 1'b1, 7'b0010001, 4'd6},  // R6 cancelled
        '{3'b000, 2'd0, 6'b000111, 1'b1, 7'b1111001, 4'd5},  // R5 errors + idle
        '{3'b110, 2'd0, 6'b000000, 1'b1, 7'b1111001, 4'd5},  // R5
        '{3'b110, 2'd1, 6'b000000, 1'b1, 7'b1111000, 4'd5},  // R5 errors survive
        '{3'b000, 2'd0, 6'b000000, 1'b0, 7'b0000000, 4'd4},  // R4 enable low
        '{3'b000, 2'd0, 6'b000100, 1'b0, 7'b0001000, 4'd7},  // R7 idle set wins
        '{3'b000, 2'd0, 6'b000000, 1'b1, 7'b0001000, 4'd4},  // R4 idle holds
        '{3'b110, 2'd0, 6'b100000, 1'b1, 7'b0001001, 4'd2},  // R2
        '{3'b110, 2'd1, 6'b100000, 1'b1, 7'b0001001, 4'd7},  // R7 ready set wins
        '{3'b110, 2'd0, 6'b010000, 1'b1, 7'b0001011, 4'd7},  // R7
        '{3'b101, 2'd1, 6'b010000, 1'b1, 7'b0001011, 4'd7},  // R7 tx set wins
        '{3'b110, 2'd0, 6'b000000, 1'b1, 7'b0001011, 4'd6},  // R6 arm
        '{3'b110, 2'd2, 6'b000000, 1'b1, 7'b0001011, 4'd6},  // R6 other address
        '{3'b101, 2'd1, 6'b000000, 1'b1, 7'b0001011, 4'd6}   // R6 cancelled
    };

    task automatic check(input string req, input string what,
                         input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] cmd, input logic [1:0] addr,
                         input logic [5:0] set, input logic en);
        {bus_sel, bus_rd, bus_wr} = cmd;
        bus_addr = addr;
        {rx_done, tx_empty_set, tx_done_set, idle_set, noise_set, frame_set} = set;
        rx_en = en;
    endtask

    // Drive at negedge, let one edge pass, sample 1 ns after it.
    task automatic step(input logic [2:0] cmd, input logic [1:0] addr,
                        input logic [5:0] set, input logic en);
        @(negedge clk);
        drive(cmd, addr, set, en);
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog all actual=expired expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check("R10", "status in reset", status, 7'b0);
        check("R10", "irq in reset", {6'b0, irq}, 7'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NROW; i++) begin
            step(TBL[i].cmd, TBL[i].addr, TBL[i].set, TBL[i].en);
            check($sformatf("R%0d", TBL[i].req), $sformatf("row %0d status", i),
                  status, TBL[i].exp);
            check("R1", $sformatf("row %0d irq", i), {6'b0, irq}, {6'b0, |TBL[i].exp});
        end

        // R8: character completes with ready still set -> no load, overrun.
        @(negedge clk);
        drive(3'b000, 2'd0, 6'b100000, 1'b1);
        #1;
        check("R8", "rx_load blocked", {6'b0, rx_load}, 7'b0);
        @(posedge clk); #1;
        check("R8", "overrun set", status, 7'b0011011);

        // R8/R7: completion during the consuming data read loads, no new overrun.
        step(3'b110, 2'd0, 6'b000000, 1'b1);
        @(negedge clk);
        drive(3'b110, 2'd1, 6'b100000, 1'b1);
        #1;
        check("R8", "rx_load granted on consume", {6'b0, rx_load}, 7'b1);
        @(posedge clk); #1;
        check("R7", "ready kept on consume", status, 7'b0011011);

        // R5: single low enable cycle clears errors and idle.
        step(3'b000, 2'd0, 6'b000000, 1'b0);
        check("R5", "errors dropped", status, 7'b0000011);
        step(3'b110, 2'd0, 6'b000000, 1'b1);
        step(3'b110, 2'd1, 6'b000000, 1'b1);
        check("R2", "ready consumed", status, 7'b0000010);

        // R1: enable masking of the only pending cause (bit 1).
        @(negedge clk);
        drive(3'b000, 2'd0, 6'b000000, 1'b1);
        irq_en = 7'b1111101;
        #1;
        check("R1", "irq masked", {6'b0, irq}, 7'b0);
        irq_en = 7'b0000010;
        #1;
        check("R1", "irq enabled cause", {6'b0, irq}, 7'b1);

        // R10: reset mid-run clears a pending flag.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R10", "status after reset", status, 7'b0);
        check("R10", "irq after reset", {6'b0, irq}, 7'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule